// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

This block joins two 18-bit ports, A and B, with one storage path per direction. Each path holds one word that either tracks its source port (transparent) or captures it on a rising edge of that path's own strobe input, and a hold-mask input can block those captures. A per-path active-low drive request decides whether the destination port is driven. Because an on-chip tristate pin is not practical, each port is split into an input bus, an output bus and a drive-enable output. The surrounding logic joins these into a pad or a shared bus.

One system clock runs the block. All data and control pins are registered once at the input. The strobe pin is treated as a slow signal, and a rising edge of it is found by comparing two successive samples. While transparent, the storage loads on every system cycle. A change at the input therefore reaches the stored word and the drive-enable two system clock edges after it was set up. The two paths share only the clock and the reset. If both drive requests are active at once, both drive-enables assert and nothing arbitrates between them.

Top module: `dual_path_xcvr`

## Requirements
- R1: After reset, both stored words (a_out, b_out) read zero and both drive-enables (a_drive, b_drive) are 0.
- R2: While a path's transparent input is 1, its destination output equals the source value presented two clock edges earlier, whatever its strobe and hold-mask inputs do.
- R3: With transparent at 0 and hold-mask at 0, a 0-to-1 change between two successive samples of the strobe loads the source value of the second sample. The result appears at the destination two edges after that sample was presented.
- R4: With transparent at 0, a strobe that stays at 0 or stays at 1 leaves the stored word unchanged, even while the source changes.
- R5: With transparent at 0 and hold-mask at 1, a rising strobe leaves the stored word unchanged.
- R6: The drive request is active low. A 0 sets the destination drive-enable to 1 two edges later, and a 1 clears it to 0 two edges later.
- R7: If transparent falls while the strobe is steady at 1, the path keeps the last value loaded in transparent mode and ignores later source changes.
- R8: The A-to-B and B-to-A paths are independent. Both drive-enables can be 1 in the same cycle, each output carries its own stored word, and no control of one path changes the other path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 18 | Value seen on port A (source of the A-to-B path) |
| a_out | output | 18 | Stored word of the B-to-A path, to be driven onto port A |
| a_drive | output | 1 | Drive-enable for port A |
| b_in | input | 18 | Value seen on port B (source of the B-to-A path) |
| b_out | output | 18 | Stored word of the A-to-B path, to be driven onto port B |
| b_drive | output | 1 | Drive-enable for port B |
| ab_transp | input | 1 | A-to-B transparent select, active high |
| ab_strobe | input | 1 | A-to-B capture strobe, rising edge |
| ab_mask | input | 1 | A-to-B hold-mask, 1 blocks strobe captures |
| ab_drv_n | input | 1 | A-to-B drive request, active low |
| ba_transp | input | 1 | B-to-A transparent select, active high |
| ba_strobe | input | 1 | B-to-A capture strobe, rising edge |
| ba_mask | input | 1 | B-to-A hold-mask, 1 blocks strobe captures |
| ba_drv_n | input | 1 | B-to-A drive request, active low |

## Verification
The hardest case to reach is the one in R7. Transparent mode must end while the strobe is already high and then stay high for several cycles as the source keeps changing. Random stimulus seldom keeps all three conditions in that order, so a directed sequence sets them up on purpose and reads the held word back on the destination output. Masked rising edges and both paths driving at once are also forced by directed steps. Between these steps, biased random cycles mix every mode on both paths.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
   typedef struct packed {
      logic transp;
      logic strobe;
      logic mask;
      logic drv_n;
   } dir_ctrl_t;

   localparam dir_ctrl_t CTRL_IDLE = '{transp: 1'b0, strobe: 1'b0, mask: 1'b0, drv_n: 1'b1};
   localparam int NUM_DIRS = 2;
endpackage

// File: rtl/xcvr_in_stage.sv
module xcvr_in_stage
   import xcvr_pkg::*;
#(
   parameter int W      = 18,
   parameter int IN_REG = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [W-1:0]    data_i,
   input  dir_ctrl_t       ctrl_i,
   output logic [W-1:0]    data_o,
   output dir_ctrl_t       ctrl_o
);
   initial begin
      assert (W >= 1) else $error("xcvr_in_stage: W must be positive");
      assert (IN_REG == 0 || IN_REG == 1) else $error("xcvr_in_stage: IN_REG must be 0 or 1");
   end

   generate
      if (IN_REG != 0) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               data_o <= '0;
               ctrl_o <= CTRL_IDLE;
            end else begin
               data_o <= data_i;
               ctrl_o <= ctrl_i;
            end
         end
      end else begin : g_pass
         always_comb begin
            data_o = data_i;
            ctrl_o = ctrl_i;
         end
      end
   endgenerate
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
   import xcvr_pkg::*;
#(
   parameter int          W       = 18,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [W-1:0]    src_q,
   input  dir_ctrl_t       ctrl_q,
   output logic [W-1:0]    word,
   output logic            drive
);
   logic strobe_prev;
   logic strobe_rise;
   logic load;

   initial begin
      assert (W >= 1) else $error("xcvr_lane: W must be positive");
   end

   assign strobe_rise = ctrl_q.strobe & ~strobe_prev;
   assign load        = ctrl_q.transp | (strobe_rise & ~ctrl_q.mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_prev <= 1'b0;
         word        <= RST_VAL;
         drive       <= 1'b0;
      end else begin
         strobe_prev <= ctrl_q.strobe;
         drive       <= ~ctrl_q.drv_n;
         if (load) word <= src_q;
      end
   end

   // transparent select loads every cycle
   p_transp_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q.transp |=> word == $past(src_q));
   // rising strobe, unmasked, captures the source
   p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.transp && ctrl_q.strobe && !strobe_prev && !ctrl_q.mask) |=> word == $past(src_q));
   // steady strobe holds the word
   p_steady_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.transp && (ctrl_q.strobe == strobe_prev)) |=> $stable(word));
   // hold-mask blocks captures
   p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.transp && ctrl_q.mask) |=> $stable(word));
   // drive request is active low
   p_drive_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q.drv_n |=> !drive);
endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr
   import xcvr_pkg::*;
#(
   parameter int           W       = 18,
   parameter int           IN_REG  = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] a_in,
   output logic [W-1:0] a_out,
   output logic         a_drive,
   input  logic [W-1:0] b_in,
   output logic [W-1:0] b_out,
   output logic         b_drive,
   input  logic         ab_transp,
   input  logic         ab_strobe,
   input  logic         ab_mask,
   input  logic         ab_drv_n,
   input  logic         ba_transp,
   input  logic         ba_strobe,
   input  logic         ba_mask,
   input  logic         ba_drv_n
);
   localparam int ND = NUM_DIRS;

   logic [W-1:0] src_raw  [ND];
   dir_ctrl_t    ctrl_raw [ND];
   logic [W-1:0] src_q    [ND];
   dir_ctrl_t    ctrl_q   [ND];
   logic [W-1:0] word     [ND];
   logic         drive    [ND];

   initial begin
      assert (W >= 1) else $error("dual_path_xcvr: W must be positive");
      assert (IN_REG == 0 || IN_REG == 1) else $error("dual_path_xcvr: IN_REG must be 0 or 1");
   end

   // index 0: A to B, index 1: B to A
   assign src_raw[0]  = a_in;
   assign src_raw[1]  = b_in;
   assign ctrl_raw[0] = '{transp: ab_transp, strobe: ab_strobe, mask: ab_mask, drv_n: ab_drv_n};
   assign ctrl_raw[1] = '{transp: ba_transp, strobe: ba_strobe, mask: ba_mask, drv_n: ba_drv_n};

   generate
      for (genvar d = 0; d < ND; d++) begin : g_dir
         xcvr_in_stage #(.W(W), .IN_REG(IN_REG)) u_in (
            .clk    (clk),
            .rst_n  (rst_n),
            .data_i (src_raw[d]),
            .ctrl_i (ctrl_raw[d]),
            .data_o (src_q[d]),
            .ctrl_o (ctrl_q[d])
         );
         xcvr_lane #(.W(W), .RST_VAL(RST_VAL)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_q  (src_q[d]),
            .ctrl_q (ctrl_q[d]),
            .word   (word[d]),
            .drive  (drive[d])
         );
      end
   endgenerate

   assign b_out   = word[0];
   assign b_drive = drive[0];
   assign a_out   = word[1];
   assign a_drive = drive[1];

   generate
      if (IN_REG != 0) begin : g_port_chk
         // port-level release of each destination, independent per path
         p_b_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $past(ab_drv_n, 2) |-> !b_drive);
         p_a_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $past(ba_drv_n, 2) |-> !a_drive);
      end
   endgenerate
endmodule

// File: tb/dual_path_xcvr_test.sv
module dual_path_xcvr_test;
   localparam int W        = 18;
   localparam int CLK_PER  = 10;
   localparam int WATCHDOG = 100000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic [W-1:0] a_out, b_out;
   logic         a_drive, b_drive;
   logic ab_transp = 0, ab_strobe = 0, ab_mask = 0, ab_drv_n = 1;
   logic ba_transp = 0, ba_strobe = 0, ba_mask = 0, ba_drv_n = 1;

   int checks = 0;
   int fails  = 0;
   int contention = 0;
   bit done = 0;

   // model state per direction: 0 = A to B, 1 = B to A
   logic [W-1:0] st [2];
   logic         dv [2];
   logic         prev_stb [2];
   logic [W-1:0] exp1_w [2], exp2_w [2];
   logic         exp1_d [2], exp2_d [2];
   string        tag1_w [2], tag2_w [2];
   string        tag1_d [2], tag2_d [2];

   dual_path_xcvr #(.W(W)) uut (
      .clk(clk), .rst_n(rst_n),
      .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
      .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
      .ab_transp(ab_transp), .ab_strobe(ab_strobe), .ab_mask(ab_mask), .ab_drv_n(ab_drv_n),
      .ba_transp(ba_transp), .ba_strobe(ba_strobe), .ba_mask(ba_mask), .ba_drv_n(ba_drv_n)
   );

   always #(CLK_PER/2) clk = ~clk;

   function automatic logic [W-1:0] next_word(input logic [W-1:0] cur, input logic [W-1:0] src,
                                              input logic tr, input logic sb, input logic pv,
                                              input logic mk);
      if (tr) return src;
      if (sb && !pv && !mk) return src;
      return cur;
   endfunction

   function automatic string word_tag(input logic tr, input logic sb, input logic pv, input logic mk);
      if (tr) return "R2";
      if (sb && !pv && mk) return "R5";
      if (sb && !pv) return "R3";
      return "R4";
   endfunction

   task automatic check(input string req, input string what, input logic [W-1:0] act,
                        input logic [W-1:0] expv);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
      end
   endtask

   // one cycle: check outputs for stimulus of two steps back, then apply new stimulus
   task automatic step(input logic [W-1:0] va, input logic [W-1:0] vb,
                       input logic t0, input logic s0, input logic m0, input logic n0,
                       input logic t1, input logic s1, input logic m1, input logic n1,
                       input string ovr);
      logic [W-1:0] src [2];
      logic tr [2], sb [2], mk [2], dn [2];
      check(tag2_w[0], "b_out", b_out, exp2_w[0]);
      check(tag2_d[0], "b_drive", {{(W-1){1'b0}}, b_drive}, {{(W-1){1'b0}}, exp2_d[0]});
      check(tag2_w[1], "a_out", a_out, exp2_w[1]);
      check(tag2_d[1], "a_drive", {{(W-1){1'b0}}, a_drive}, {{(W-1){1'b0}}, exp2_d[1]});
      if (exp2_d[0] && exp2_d[1]) contention++;
      src[0] = va; src[1] = vb;
      tr[0] = t0; sb[0] = s0; mk[0] = m0; dn[0] = n0;
      tr[1] = t1; sb[1] = s1; mk[1] = m1; dn[1] = n1;
      for (int d = 0; d < 2; d++) begin
         exp2_w[d] = exp1_w[d]; exp2_d[d] = exp1_d[d];
         tag2_w[d] = tag1_w[d]; tag2_d[d] = tag1_d[d];
         tag1_w[d] = (ovr != "") ? ovr : word_tag(tr[d], sb[d], prev_stb[d], mk[d]);
         tag1_d[d] = (!n0 && !n1) ? "R8" : "R6";
         st[d] = next_word(st[d], src[d], tr[d], sb[d], prev_stb[d], mk[d]);
         dv[d] = !dn[d];
         prev_stb[d] = sb[d];
         exp1_w[d] = st[d]; exp1_d[d] = dv[d];
      end
      a_in = va; b_in = vb;
      ab_transp = t0; ab_strobe = s0; ab_mask = m0; ab_drv_n = n0;
      ba_transp = t1; ba_strobe = s1; ba_mask = m1; ba_drv_n = n1;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      for (int d = 0; d < 2; d++) begin
         st[d] = '0; dv[d] = 0; prev_stb[d] = 0;
         exp1_w[d] = '0; exp2_w[d] = '0; exp1_d[d] = 0; exp2_d[d] = 0;
         tag1_w[d] = "R1"; tag2_w[d] = "R1"; tag1_d[d] = "R1"; tag2_d[d] = "R1";
      end
      void'($urandom(32'h1A2B3C));
      repeat (3) @(negedge clk);
      // R1: reset state visible at the ports
      check("R1", "b_out reset", b_out, '0);
      check("R1", "a_out reset", a_out, '0);
      check("R1", "drives reset", {{(W-2){1'b0}}, a_drive, b_drive}, '0);
      rst_n = 1'b1;

      // R7 on A to B: load in transparent with strobe high, then drop transparent
      step(18'h12345, 18'h0, 1,1,0,1, 0,0,0,1, "");
      step(18'h2AAAA, 18'h0, 1,1,0,1, 0,0,0,1, "R2");
      step(18'h3F00F, 18'h0, 0,1,0,1, 0,0,0,1, "R7");
      for (int i = 0; i < 4; i++)
         step(W'($urandom), 18'h0, 0,1,0,1, 0,0,0,1, "R7");
      // R5: masked rising strobe on B to A
      step(18'h0, 18'h11111, 0,0,0,1, 0,0,1,1, "");
      step(18'h0, 18'h22222, 0,0,0,1, 0,1,1,1, "R5");
      step(18'h0, 18'h33333, 0,0,0,1, 0,1,1,1, "R4");
      // R3: unmasked rising strobe on B to A
      step(18'h0, 18'h0, 0,0,0,1, 0,0,0,1, "");
      step(18'h0, 18'h2D2D2, 0,0,0,1, 0,1,0,1, "R3");
      step(18'h0, 18'h00FFF, 0,0,0,1, 0,1,0,1, "R4");
      // R8: both paths driving with different words
      step(18'h15555, 18'h0AAAA, 1,0,0,0, 1,0,0,0, "R8");
      step(18'h15555, 18'h0AAAA, 0,0,0,0, 0,0,0,0, "R8");
      step(18'h00001, 18'h3FFFE, 0,0,0,0, 0,0,0,0, "R8");
      // R6: release one side only
      step(18'h0, 18'h0, 0,0,0,1, 0,0,0,0, "");
      step(18'h0, 18'h0, 0,0,0,1, 0,0,0,0, "");

      // biased random mix
      for (int i = 0; i < 600; i++) begin
         logic [W-1:0] va, vb;
         va = W'($urandom); vb = W'($urandom);
         step(va, vb,
              ($urandom % 4) == 0, $urandom % 2, ($urandom % 4) == 0, $urandom % 2,
              ($urandom % 4) == 0, $urandom % 2, ($urandom % 4) == 0, $urandom % 2, "");
      end
      // drain the pipeline with idle controls
      step(18'h0, 18'h0, 0,0,0,1, 0,0,0,1, "");
      step(18'h0, 18'h0, 0,0,0,1, 0,0,0,1, "");
      step(18'h0, 18'h0, 0,0,0,1, 0,0,0,1, "");
      if (!done) begin
         done = 1;
         $display("note: %0d cycles with both ports driven", contention);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule